// File: doc/BRIEF.md
# Transmit Pause-Frame Scheduler

This block sits on a MAC transmit path between a byte-stream frame source and the transmit pipeline. It forwards ordinary data frames byte by byte. On software request it builds and inserts an Ethernet flow-control PAUSE frame carrying a 16-bit quanta value. It keeps every frame apart from the next by a minimum number of idle cycles. Once the PAUSE frame has left, it raises a single-cycle completion event.

A write pulse sets a pending request. Any data frame already under way runs to its end, and no new data frame may start until the PAUSE frame has gone out. The hardware then drops the request bit and data transmission carries on. Two halt inputs stop new data frames from starting: one is a software graceful stop and the other shows that the link partner has paused us. Neither halt holds back a PAUSE frame. The block adds no CRC. The downstream pipeline appends it when `crc_auto` is high, and the idle gap grows to leave room for those bytes.

Top module: `pause_tx_sched`

## Requirements
- R1: After reset, `tx_valid`, `pause_req_pending` and `pause_sent` are 0, and with no halt `src_ready` is 1.
- R2: With no request pending and no halt, each source byte reaches `tx_data` unchanged and in order. `tx_last` marks the byte that carried `src_last`.
- R3: A request written while a data frame is being forwarded lets that frame finish intact. The PAUSE frame is then the next frame out, and it goes ahead of any data frame the source has waiting.
- R4: The PAUSE frame is 60 bytes long, with `tx_last` on byte 59. Byte 0 leaves first. Bytes 0-5 are 01 80 C2 00 00 01 and bytes 6-11 are `SRC_ADDR`, most significant byte first. Bytes 12-13 are 88 08 and bytes 14-15 are 00 01. Bytes 16-17 are the `pause_quanta` value captured as the frame starts, high byte first. Bytes 18-59 are 00.
- R5: `pause_sent` is high for exactly one cycle, the cycle right after the one that shows the last PAUSE byte.
- R6: `pause_req_pending` reads 1 from the cycle after a `pause_req_wr` pulse and reads 0 from the cycle in which `pause_sent` is high. After that, data frames flow again.
- R7: A further `pause_req_wr` while a request is pending or its frame is in flight has no effect: exactly one PAUSE frame and one `pause_sent` pulse result.
- R8: While `graceful_stop` or `rx_pause_hold` is high, no new data frame starts and `src_ready` stays low between frames. A data frame already started finishes. Data resumes once both halts are low.
- R9: A pending PAUSE frame is sent even while either halt input is high.
- R10: Between the last byte of one frame and the first byte of the next there are at least G idle cycles, where G = 3 when `crc_auto` = 0. When `crc_auto` = 1, G = 7 with `WIDE_IF` = 0 and G = 5 with `WIDE_IF` = 1. When the next frame is already waiting, the gap is exactly G.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_req_wr | input | 1 | Write pulse that sets the PAUSE request |
| pause_quanta | input | 16 | Pause time in quanta, placed in the PAUSE frame |
| graceful_stop | input | 1 | Software halt of new data frames |
| rx_pause_hold | input | 1 | Halt of new data frames due to a received PAUSE |
| crc_auto | input | 1 | Downstream appends CRC, so the longer gap applies |
| src_valid | input | 1 | Source byte valid |
| src_data | input | 8 | Source byte |
| src_last | input | 1 | Source byte ends its frame |
| src_ready | output | 1 | Source byte accepted at this edge when valid |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Output byte ends its frame |
| pause_req_pending | output | 1 | Read value of the request bit |
| pause_sent | output | 1 | One-cycle event after a PAUSE frame completes |

## Verification
The gap assertion assumes that `crc_auto` stays steady from the end of one frame until the next frame starts, since changing it inside a gap would change the bound partway through. The bench only changes it after many idle cycles. The halt assertion assumes the source keeps `src_last` truthful, so that the forwarding state always ends. The bench sends only frames it fully defines, and it toggles the halts only between the bytes it drives, on falling edges.

// File: rtl/pause_tx_sched.sv
module pause_tx_sched #(
  parameter bit          WIDE_IF     = 1'b0,
  parameter logic [47:0] SRC_ADDR    = 48'h02_00_00_00_00_01,
  parameter int          FRAME_BYTES = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pause_req_wr,
  input  logic [15:0] pause_quanta,
  input  logic        graceful_stop,
  input  logic        rx_pause_hold,
  input  logic        crc_auto,
  input  logic        src_valid,
  input  logic [7:0]  src_data,
  input  logic        src_last,
  output logic        src_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        pause_req_pending,
  output logic        pause_sent
);
  localparam int IDX_W   = $clog2(FRAME_BYTES);
  localparam int GAP_CRC = WIDE_IF ? 5 : 7;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAUSE} st_t;
  st_t st;

  logic [IDX_W-1:0] idx;
  logic [15:0]      quanta_q;
  logic [2:0]       gap_cnt;
  logic             req_q, done_q, is_pause_q;
  logic             tx_valid_q, tx_last_q;
  logic [7:0]       tx_data_q, pbyte;

  wire [2:0] gap_min     = crc_auto ? 3'(GAP_CRC) : 3'd3;
  wire       gap_ok      = !tx_valid_q && (gap_cnt >= gap_min - 3'd1);
  wire       halted      = graceful_stop | rx_pause_hold;
  wire       data_busy   = (st == S_DATA);
  wire       start_pause = (st == S_IDLE) && gap_ok && req_q;
  wire       pause_end   = (st == S_PAUSE) && (idx == IDX_W'(FRAME_BYTES - 1));
  wire       done_evt    = tx_valid_q && tx_last_q && is_pause_q;

  assign src_ready = data_busy || ((st == S_IDLE) && gap_ok && !req_q && !halted);
  wire   take      = src_valid && src_ready;

  always_comb begin
    pbyte = 8'h00;
    case (int'(idx))
      0:  pbyte = 8'h01;
      1:  pbyte = 8'h80;
      2:  pbyte = 8'hC2;
      5:  pbyte = 8'h01;
      6, 7, 8, 9, 10, 11: pbyte = 8'(SRC_ADDR >> (8 * (11 - int'(idx))));
      12: pbyte = 8'h88;
      13: pbyte = 8'h08;
      15: pbyte = 8'h01;
      16: pbyte = quanta_q[15:8];
      17: pbyte = quanta_q[7:0];
      default: pbyte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      quanta_q   <= '0;
      gap_cnt    <= 3'd7;
      req_q      <= 1'b0;
      done_q     <= 1'b0;
      is_pause_q <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_last_q  <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      tx_last_q  <= 1'b0;
      if (take) begin
        tx_valid_q <= 1'b1;
        tx_data_q  <= src_data;
        tx_last_q  <= src_last;
        is_pause_q <= 1'b0;
        st         <= src_last ? S_IDLE : S_DATA;
      end else if (start_pause) begin
        tx_valid_q <= 1'b1;
        tx_data_q  <= 8'h01;
        is_pause_q <= 1'b1;
        quanta_q   <= pause_quanta;
        idx        <= IDX_W'(1);
        st         <= S_PAUSE;
      end else if (st == S_PAUSE) begin
        tx_valid_q <= 1'b1;
        tx_data_q  <= pbyte;
        tx_last_q  <= pause_end;
        idx        <= idx + IDX_W'(1);
        if (pause_end) st <= S_IDLE;
      end
      gap_cnt <= tx_valid_q ? 3'd0 : ((gap_cnt == 3'd7) ? 3'd7 : gap_cnt + 3'd1);
      done_q  <= done_evt;
      req_q   <= done_evt ? 1'b0 : (req_q | pause_req_wr);
    end
  end

  assign tx_valid          = tx_valid_q;
  assign tx_data           = tx_data_q;
  assign tx_last           = tx_last_q;
  assign pause_req_pending = req_q;
  assign pause_sent        = done_q;
endmodule

// File: rtl/pause_tx_sched_chk.sv
module pause_tx_sched_chk #(
  parameter bit WIDE_IF = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_last,
  input logic src_ready,
  input logic graceful_stop,
  input logic rx_pause_hold,
  input logic crc_auto,
  input logic data_busy,
  input logic pause_req_pending,
  input logic pause_sent
);
  logic [3:0] idle_q;
  logic       in_tx_q;
  wire  [3:0] gmin  = crc_auto ? (WIDE_IF ? 4'd5 : 4'd7) : 4'd3;
  wire        start = tx_valid && !in_tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q  <= 4'd15;
      in_tx_q <= 1'b0;
    end else begin
      idle_q  <= tx_valid ? 4'd0 : ((idle_q == 4'd15) ? 4'd15 : idle_q + 4'd1);
      if (tx_valid) in_tx_q <= !tx_last;
    end
  end

  assert_last_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
  assert_min_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle_q >= gmin);
  assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((graceful_stop || rx_pause_hold) && !data_busy) |-> !src_ready);
  assert_sent_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_sent |-> $past(tx_valid && tx_last));
  assert_sent_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_sent |=> !pause_sent);
  assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_sent |-> !pause_req_pending);
  assert_req_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_req_pending) |-> pause_sent);
endmodule

bind pause_tx_sched pause_tx_sched_chk #(.WIDE_IF(WIDE_IF)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_last(tx_last),
  .src_ready(src_ready), .graceful_stop(graceful_stop), .rx_pause_hold(rx_pause_hold),
  .crc_auto(crc_auto), .data_busy(data_busy),
  .pause_req_pending(pause_req_pending), .pause_sent(pause_sent)
);

// File: tb/pause_tx_sched_tb.sv
module pause_tx_sched_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pause_req_wr = 0, graceful_stop = 0, rx_pause_hold = 0, crc_auto = 0;
  logic [15:0] pause_quanta = 16'h0;
  logic src_valid = 0, src_last = 0;
  logic [7:0] src_data = 8'h0;
  logic src_ready, tx_valid, tx_last, pause_req_pending, pause_sent;
  logic [7:0] tx_data;

  localparam logic [47:0] SA = 48'h02_00_00_00_00_01;

  always #5 clk = ~clk;

  pause_tx_sched dut_i (
    .clk(clk), .rst_n(rst_n), .pause_req_wr(pause_req_wr), .pause_quanta(pause_quanta),
    .graceful_stop(graceful_stop), .rx_pause_hold(rx_pause_hold), .crc_auto(crc_auto),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last), .src_ready(src_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .pause_req_pending(pause_req_pending), .pause_sent(pause_sent)
  );

  int n_chk = 0, n_err = 0;
  int fr_n = 0, pause_n = 0, done_n = 0, cur_len = 0, idle = 1000;
  int fr_len[32], fr_gap[32];
  logic [7:0] fr_b0[32];
  logic [7:0] pbuf[128];
  logic [7:0] pz[60];
  bit in_fr = 0;

  always @(negedge clk) if (rst_n) begin
    if (pause_sent) done_n++;
    if (tx_valid) begin
      if (!in_fr) begin
        fr_gap[fr_n % 32] = idle;
        fr_b0[fr_n % 32] = tx_data;
        cur_len = 0;
        in_fr = 1;
      end
      if (cur_len < 128) pbuf[cur_len] = tx_data;
      cur_len++;
      idle = 0;
      if (tx_last) begin
        fr_len[fr_n % 32] = cur_len;
        if (cur_len == 60 && pbuf[0] == 8'h01) begin
          for (int i = 0; i < 60; i++) pz[i] = pbuf[i];
          pause_n++;
        end
        fr_n++;
        in_fr = 0;
      end
    end else idle++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pb(int i, logic [15:0] q);
    case (i)
      0: return 8'h01; 1: return 8'h80; 2: return 8'hC2; 5: return 8'h01;
      6, 7, 8, 9, 10, 11: return 8'(SA >> (8 * (11 - i)));
      12: return 8'h88; 13: return 8'h08; 15: return 8'h01;
      16: return q[15:8]; 17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic send(int len, logic [7:0] base);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      src_valid = 1; src_data = base + 8'(i); src_last = (i == len - 1);
      #1;
      while (!src_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      #1 src_valid = 0;
    end
  endtask

  task automatic req_pulse();
    @(negedge clk); pause_req_wr = 1;
    @(negedge clk); pause_req_wr = 0;
  endtask

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      if (pause_sent) got = 1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_valid && !pause_req_pending && !pause_sent, "R1 reset outputs",
        {tx_valid, pause_req_pending, pause_sent}, 0);
    chk(src_ready, "R1 src_ready", src_ready, 1);
  endtask

  task automatic t_data();
    int f0 = fr_n;
    bit ok = 1;
    send(20, 8'h10);
    idle_wait(4);
    chk(fr_n == f0 + 1 && fr_len[f0 % 32] == 20, "R2 frame length", fr_len[f0 % 32], 20);
    for (int i = 0; i < 20; i++) if (pbuf[i] !== 8'h10 + 8'(i)) ok = 0;
    chk(ok, "R2 byte order", ok, 1);
  endtask

  task automatic t_gap();
    int f0;
    crc_auto = 0; idle_wait(10);
    f0 = fr_n;
    send(8, 8'h20); send(8, 8'h30); idle_wait(5);
    chk(fr_gap[(f0 + 1) % 32] == 3, "R10 gap no CRC", fr_gap[(f0 + 1) % 32], 3);
    crc_auto = 1; idle_wait(10);
    f0 = fr_n;
    send(8, 8'h40); send(8, 8'h50); idle_wait(10);
    chk(fr_gap[(f0 + 1) % 32] == 7, "R10 gap with CRC", fr_gap[(f0 + 1) % 32], 7);
    crc_auto = 0; idle_wait(10);
  endtask

  task automatic t_pause_idle();
    int d0 = done_n, p0 = pause_n;
    bit got, ok = 1;
    pause_quanta = 16'h1234;
    req_pulse();
    chk(pause_req_pending, "R6 pending after write", pause_req_pending, 1);
    idle_wait(4);
    pause_quanta = 16'hFFFF;
    wait_done(got);
    chk(got && !pause_req_pending, "R6 cleared at event", pause_req_pending, 0);
    chk(pause_n == p0 + 1, "R4 one pause frame", pause_n - p0, 1);
    for (int i = 0; i < 60; i++) if (pz[i] !== exp_pb(i, 16'h1234)) ok = 0;
    chk(ok, "R4 pause content", pz[16] * 256 + pz[17], 16'h1234);
    @(negedge clk);
    chk(!pause_sent && done_n == d0 + 1, "R5 single pulse", done_n - d0, 1);
  endtask

  task automatic t_pause_mid();
    int f0 = fr_n;
    bit got;
    pause_quanta = 16'h0777;
    fork
      send(30, 8'hA0);
      begin idle_wait(8); req_pulse(); end
    join
    chk(pause_req_pending, "R3 pending during frame", pause_req_pending, 1);
    send(10, 8'hB0);
    idle_wait(10);
    chk(fr_len[f0 % 32] == 30 && fr_b0[f0 % 32] == 8'hA0, "R3 data frame intact",
        fr_len[f0 % 32], 30);
    chk(fr_b0[(f0 + 1) % 32] == 8'h01 && fr_len[(f0 + 1) % 32] == 60, "R3 pause next",
        fr_b0[(f0 + 1) % 32], 8'h01);
    chk(fr_b0[(f0 + 2) % 32] == 8'hB0 && fr_n == f0 + 3, "R6 data resumes",
        fr_b0[(f0 + 2) % 32], 8'hB0);
    chk(fr_gap[(f0 + 1) % 32] == 3, "R10 gap before pause", fr_gap[(f0 + 1) % 32], 3);
    got = 0;
  endtask

  task automatic t_double();
    int d0 = done_n, p0 = pause_n;
    bit got;
    pause_quanta = 16'h0042;
    req_pulse();
    idle_wait(10);
    req_pulse();
    wait_done(got);
    idle_wait(100);
    chk(pause_n == p0 + 1, "R7 one frame per request", pause_n - p0, 1);
    chk(done_n == d0 + 1 && !pause_req_pending, "R7 one event", done_n - d0, 1);
  endtask

  task automatic t_halt();
    int f0 = fr_n;
    bit got;
    fork
      send(40, 8'hC0);
      begin idle_wait(10); graceful_stop = 1; end
    join
    idle_wait(5);
    chk(fr_n == f0 + 1 && fr_len[f0 % 32] == 40, "R8 started frame finishes",
        fr_len[f0 % 32], 40);
    fork send(5, 8'hD0); join_none
    idle_wait(30);
    chk(fr_n == f0 + 1 && !src_ready, "R8 graceful stop blocks", fr_n - f0, 1);
    pause_quanta = 16'h0100;
    req_pulse();
    wait_done(got);
    idle_wait(2);
    chk(got && fr_n == f0 + 2 && fr_b0[(f0 + 1) % 32] == 8'h01, "R9 pause while halted",
        fr_n - f0, 2);
    idle_wait(20);
    chk(fr_n == f0 + 2, "R8 data still blocked", fr_n - f0, 2);
    graceful_stop = 0;
    idle_wait(30);
    chk(fr_n == f0 + 3 && fr_b0[(f0 + 2) % 32] == 8'hD0, "R8 resume after stop",
        fr_b0[(f0 + 2) % 32], 8'hD0);
    rx_pause_hold = 1;
    fork send(4, 8'hE0); join_none
    idle_wait(20);
    chk(fr_n == f0 + 3 && !src_ready, "R8 received pause blocks", fr_n - f0, 3);
    rx_pause_hold = 0;
    idle_wait(20);
    chk(fr_n == f0 + 4 && fr_b0[(f0 + 3) % 32] == 8'hE0, "R8 resume after hold",
        fr_b0[(f0 + 3) % 32], 8'hE0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_data();
    t_gap();
    t_pause_idle();
    t_pause_mid();
    t_double();
    t_halt();
    idle_wait(5);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule